// File: doc/BRIEF.md
# Bidirectional Round-Subkey Generator for a 64-bit Block Cipher

This block turns a 64-bit key block (56 key bits plus one parity bit per byte) into the sixteen 48-bit round subkeys that a single-round iterative cipher core consumes. The same start state serves both directions. For encryption the subkeys come out first to last. For decryption they come out last to first. Decryption gets its order by rotating the two 28-bit key halves to the right instead of to the left, so no subkey is ever stored.

Two key holders feed the schedule. The master holder is written from outside. The working holder is written with a 64-bit block taken from the cipher datapath output, which lets the next key travel in-band with the data. Neither holder has a read path. A start pulse picks a holder and a direction and reloads the rotating halves. An advance strobe then steps one round per pulse. The round index wraps from 15 back to 0, and the schedule repeats.

Top module: `keysched_top`

## Requirements
- R1: After reset, `subkey_valid` is 0, `round_idx` is 0 and `subkey` is all zeros. Until the first start, `advance` does not move `round_idx`.
- R2: A cycle with `start` high reloads the schedule from the holder chosen by `src_sel` (0 = master, 1 = working). From the next cycle `round_idx` is 0 and `subkey_valid` is 1, and `subkey_valid` then stays 1.
- R3: With `decrypt` low at start, the subkey shown at `round_idx` = n (0-based) is encryption round n+1's subkey. Left rotations per round are 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1, and each is applied before that round's subkey is formed. Key 0x133457799BBCDFF1 gives 0x1B02EFFC7072 at index 0 and 0xCB3D8B0E17F5 at index 15.
- R4: With `decrypt` high at start, index n shows encryption subkey 16-n. Index 0 uses the unrotated state, and the later rounds rotate right by 1,2,2,2,2,2,2,1,2,2,2,2,2,2,1.
- R5: An advance at index 15 returns to index 0 with the same subkey as index 0 of that pass, in both directions.
- R6: The master holder is written by `mk_we` and the working holder by `wk_we`. `src_sel` picks which one a start uses.
- R7: `start` wins over `advance` in the same cycle. A start in the same cycle as a write to the chosen holder uses the holder's previous contents.
- R8: Writing either holder does not change the subkey or index of a schedule already running.
- R9: The parity bit of each key byte (bit 0 of every byte, LSB-numbered) has no effect on any subkey.
- R10: With neither `start` nor `advance`, `round_idx` and `subkey` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mk_we | input | 1 | Write strobe for the master key holder |
| mk_key | input | 64 | Key block for the master holder |
| wk_we | input | 1 | Write strobe for the working key holder |
| wk_block | input | 64 | Datapath output block for the working holder |
| start | input | 1 | Reload the schedule from the selected holder |
| src_sel | input | 1 | Holder used at start: 0 master, 1 working |
| decrypt | input | 1 | Direction latched at start: 1 gives reverse subkey order |
| advance | input | 1 | Step to the next round's subkey |
| subkey | output | 48 | Current round subkey |
| round_idx | output | 4 | Current round number, 0 to 15 |
| subkey_valid | output | 1 | A schedule has been started since reset |

## Verification
The assertions check the following on every cycle: the index behaviour on start, on advance and while idle; that the subkey stays still when nothing steps it or when only a holder is written; and that the valid flag stays set. Whether the subkey values are correct can only be shown by the bench scenarios. These compare each cycle against a reference that forms all sixteen subkeys from the table of cumulative rotations and reverses them for decryption. They also check known key/subkey pairs, holder selection, the same-cycle start and write case, and keys that differ only in parity bits.

// File: rtl/keysched_pkg.sv
package keysched_pkg;
   localparam int KEY_W  = 64;
   localparam int CD_W   = 56;
   localparam int HALF_W = 28;
   localparam int SUB_W  = 48;

   // Source bit (1 = most significant) for each selected key bit.
   localparam int unsigned PC1_T [CD_W] = '{
      57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
      10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
      63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
      14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

   localparam int unsigned PC2_T [SUB_W] = '{
      14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
      23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
      41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
      44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

   function automatic logic [CD_W-1:0] apply_pc1(input logic [KEY_W-1:0] k);
      logic [CD_W-1:0] o;
      for (int j = 0; j < CD_W; j++) o[CD_W-1-j] = k[KEY_W-int'(PC1_T[j])];
      return o;
   endfunction

   function automatic logic [SUB_W-1:0] apply_pc2(input logic [CD_W-1:0] cd);
      logic [SUB_W-1:0] o;
      for (int j = 0; j < SUB_W; j++) o[SUB_W-1-j] = cd[CD_W-int'(PC2_T[j])];
      return o;
   endfunction

   function automatic logic [HALF_W-1:0] rot_half(input logic [HALF_W-1:0] h,
                                                  input logic left, input logic two);
      case ({left, two})
         2'b10:   return {h[HALF_W-2:0], h[HALF_W-1]};
         2'b11:   return {h[HALF_W-3:0], h[HALF_W-1:HALF_W-2]};
         2'b00:   return {h[0], h[HALF_W-1:1]};
         default: return {h[1:0], h[HALF_W-1:2]};
      endcase
   endfunction

   // Total rotation over a pass, given a mask of single-place rounds.
   function automatic int pass_rotation(input logic [15:0] one_mask);
      return 32 - $countones(one_mask);
   endfunction
endpackage

// File: rtl/keysched_keystore.sv
module keysched_keystore
   import keysched_pkg::*;
#(
   parameter bit STORE_PC1 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [KEY_W-1:0] wdata,
   output logic [CD_W-1:0]  key_sel
);
   generate
      if (STORE_PC1) begin : g_narrow
         logic [CD_W-1:0] held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  held <= '0;
            else if (we) held <= apply_pc1(wdata);
         end
         assign key_sel = held;
      end else begin : g_wide
         logic [KEY_W-1:0] held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  held <= '0;
            else if (we) held <= wdata;
         end
         assign key_sel = apply_pc1(held);
      end
   endgenerate
endmodule

// File: rtl/keysched_ctrl.sv
module keysched_ctrl #(
   parameter int          ROUNDS      = 16,
   parameter logic [15:0] SHIFT1_MASK = 16'h8103,
   localparam int         RW          = $clog2(ROUNDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          decrypt,
   input  logic          advance,
   output logic          load,
   output logic          load_raw,
   output logic          step,
   output logic          rot_left,
   output logic          rot_two,
   output logic [RW-1:0] round,
   output logic          valid
);
   logic          dec_q;
   logic [RW-1:0] nxt;
   logic [RW-1:0] back;

   assign nxt      = round + 1'b1;
   assign back     = RW'(ROUNDS - 1) - round;
   assign load     = start;
   assign load_raw = decrypt;
   assign step     = advance & valid & ~start;

   always_comb begin
      if (start) begin
         rot_left = 1'b1;
         rot_two  = ~SHIFT1_MASK[0];
      end else if (dec_q) begin
         rot_left = 1'b0;
         rot_two  = ~SHIFT1_MASK[back];
      end else begin
         rot_left = 1'b1;
         rot_two  = ~SHIFT1_MASK[nxt];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         round <= '0;
         valid <= 1'b0;
         dec_q <= 1'b0;
      end else if (start) begin
         round <= '0;
         valid <= 1'b1;
         dec_q <= decrypt;
      end else if (step) begin
         round <= nxt;
      end
   end
endmodule

// File: rtl/keysched_rotor.sv
module keysched_rotor
   import keysched_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            load_raw,
   input  logic [CD_W-1:0] load_val,
   input  logic            step,
   input  logic            rot_left,
   input  logic            rot_two,
   output logic [CD_W-1:0] cd
);
   logic [CD_W-1:0] src;
   logic [CD_W-1:0] turned;

   assign src    = load ? load_val : cd;
   assign turned = {rot_half(src[CD_W-1:HALF_W], rot_left, rot_two),
                    rot_half(src[HALF_W-1:0],    rot_left, rot_two)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cd <= '0;
      else if (load && load_raw) cd <= load_val;
      else if (load || step)     cd <= turned;
   end
endmodule

// File: rtl/keysched_top.sv
module keysched_top
   import keysched_pkg::*;
#(
   parameter int          ROUNDS      = 16,
   parameter logic [15:0] SHIFT1_MASK = 16'h8103,
   parameter bit          STORE_PC1   = 1'b1,
   localparam int         RW          = $clog2(ROUNDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mk_we,
   input  logic [KEY_W-1:0] mk_key,
   input  logic             wk_we,
   input  logic [KEY_W-1:0] wk_block,
   input  logic             start,
   input  logic             src_sel,
   input  logic             decrypt,
   input  logic             advance,
   output logic [SUB_W-1:0] subkey,
   output logic [RW-1:0]    round_idx,
   output logic             subkey_valid
);
   generate
      if (ROUNDS != 16 || 2 * HALF_W != CD_W) begin : g_bad_shape
         $error("keysched_top: round count or half width unsupported");
      end
      if (pass_rotation(SHIFT1_MASK) != HALF_W) begin : g_bad_mask
         $error("keysched_top: shift mask does not rotate a full half per pass");
      end
   endgenerate

   logic [CD_W-1:0] mk_pc1, wk_pc1, cd;
   logic            load, load_raw, step, rot_left, rot_two;

   keysched_keystore #(.STORE_PC1(STORE_PC1)) u_master (
      .clk(clk), .rst_n(rst_n), .we(mk_we), .wdata(mk_key), .key_sel(mk_pc1));

   keysched_keystore #(.STORE_PC1(STORE_PC1)) u_working (
      .clk(clk), .rst_n(rst_n), .we(wk_we), .wdata(wk_block), .key_sel(wk_pc1));

   keysched_ctrl #(.ROUNDS(ROUNDS), .SHIFT1_MASK(SHIFT1_MASK)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt), .advance(advance),
      .load(load), .load_raw(load_raw), .step(step), .rot_left(rot_left),
      .rot_two(rot_two), .round(round_idx), .valid(subkey_valid));

   keysched_rotor u_rotor (
      .clk(clk), .rst_n(rst_n), .load(load), .load_raw(load_raw),
      .load_val(src_sel ? wk_pc1 : mk_pc1), .step(step), .rot_left(rot_left),
      .rot_two(rot_two), .cd(cd));

   assign subkey = apply_pc2(cd);
endmodule

// File: rtl/keysched_chk.sv
module keysched_chk #(
   parameter int RW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mk_we,
   input logic          wk_we,
   input logic          start,
   input logic          advance,
   input logic [47:0]   subkey,
   input logic [RW-1:0] round_idx,
   input logic          subkey_valid
);
   AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!subkey_valid && !start) |=> (round_idx == '0 && !subkey_valid)); // R1
   AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (round_idx == '0 && subkey_valid)); // R2
   AST_VALID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      subkey_valid |=> subkey_valid); // R2
   AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !start && subkey_valid) |=> round_idx == RW'($past(round_idx) + 1'b1)); // R5
   AST_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      ((mk_we || wk_we) && !start && !advance) |=> $stable(subkey)); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !advance) |=> ($stable(round_idx) && $stable(subkey))); // R10
endmodule

bind keysched_top keysched_chk #(.RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mk_we(mk_we), .wk_we(wk_we), .start(start),
   .advance(advance), .subkey(subkey), .round_idx(round_idx),
   .subkey_valid(subkey_valid));

// File: tb/keysched_top_tb.sv
`timescale 1ns/1ps
module keysched_top_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic mk_we = 0, wk_we = 0, start = 0, src_sel = 0, decrypt = 0, advance = 0;
   logic [63:0] mk_key = '0, wk_block = '0;
   logic [47:0] subkey;
   logic [3:0]  round_idx;
   logic        subkey_valid;

   int vectors = 0, misses = 0, cycles = 0;
   string tag = "R1";

   keysched_top u_dut (.*);

   always #5 clk = ~clk;

   int pc1_t [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,
                      60,52,44,36,63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,
                      29,21,13,5,28,20,12,4};
   int pc2_t [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
                      41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};
   int shifts [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

   // reference model state
   logic [63:0] m_mk = '0, m_wk = '0;
   logic [47:0] ks [16];
   bit  m_dec = 0, m_valid = 0;
   int  m_round = 0;

   task automatic gen(input logic [63:0] k);
      logic [55:0] base, cd;
      logic [27:0] c, d;
      int total = 0;
      for (int j = 0; j < 56; j++) base[55-j] = k[64-pc1_t[j]];
      for (int r = 0; r < 16; r++) begin
         total += shifts[r];
         c = base[55:28];
         d = base[27:0];
         for (int s = 0; s < total; s++) begin
            c = {c[26:0], c[27]};
            d = {d[26:0], d[27]};
         end
         cd = {c, d};
         for (int j = 0; j < 48; j++) ks[r][47-j] = cd[56-pc2_t[j]];
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mk = '0; m_wk = '0; m_dec = 0; m_valid = 0; m_round = 0;
         for (int r = 0; r < 16; r++) ks[r] = '0;
      end else begin
         if (start) begin
            gen(src_sel ? m_wk : m_mk);
            m_dec = decrypt; m_round = 0; m_valid = 1;
         end else if (advance && m_valid) m_round = (m_round + 1) % 16;
         if (mk_we) m_mk = mk_key;
         if (wk_we) m_wk = wk_block;
      end
   end

   function automatic logic [47:0] exp_key();
      if (!m_valid) return '0;
      return m_dec ? ks[15 - m_round] : ks[m_round];
   endfunction

   always @(negedge clk) begin
      vectors++;
      if (subkey !== exp_key() || round_idx !== 4'(m_round) || subkey_valid !== m_valid) begin
         misses++;
         $display("FAIL %s: subkey=%h idx=%0d valid=%0b expected subkey=%h idx=%0d valid=%0b",
                  tag, subkey, round_idx, subkey_valid, exp_key(), m_round, m_valid);
      end
   end

   task automatic anchor(input string t, input logic [47:0] want, input int idx);
      vectors++;
      if (subkey !== want || round_idx !== 4'(idx)) begin
         misses++;
         $display("FAIL %s: subkey=%h idx=%0d expected subkey=%h idx=%0d",
                  t, subkey, round_idx, want, idx);
      end
   endtask

   task automatic cyc(input bit s, input bit sel, input bit dec, input bit adv,
                      input bit mw, input logic [63:0] mv, input bit ww, input logic [63:0] wv);
      start = s; src_sel = sel; decrypt = dec; advance = adv;
      mk_we = mw; mk_key = mv; wk_we = ww; wk_block = wv;
      @(posedge clk); #1;
      start = 0; advance = 0; mk_we = 0; wk_we = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, '0, 0, '0);
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, '0, 0, '0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         misses++;
         $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   localparam logic [63:0] KEY_A = 64'h133457799BBCDFF1;
   localparam logic [63:0] KEY_B = 64'h0E329232EA6D0D73;
   localparam logic [47:0] A_K1  = 48'h1B02EFFC7072;
   localparam logic [47:0] A_K16 = 48'hCB3D8B0E17F5;

   initial begin
      @(posedge clk); #1;
      tag = "R1"; idle(2);
      rst_n = 1'b1;
      steps(2);                                  // R1: advance ignored before start
      idle(1);
      tag = "R2"; cyc(0, 0, 0, 0, 1, KEY_A, 0, '0);
      cyc(1, 0, 0, 0, 0, '0, 0, '0);
      anchor("R2", A_K1, 0);
      tag = "R3"; steps(15);
      anchor("R3", A_K16, 15);
      tag = "R5"; steps(1);
      anchor("R5", A_K1, 0);
      tag = "R4"; cyc(1, 0, 1, 0, 0, '0, 0, '0);
      anchor("R4", A_K16, 0);
      steps(15);
      anchor("R4", A_K1, 15);
      tag = "R5"; steps(1);
      anchor("R5", A_K16, 0);
      tag = "R6"; cyc(0, 0, 0, 0, 0, '0, 1, KEY_B);
      cyc(1, 1, 0, 0, 0, '0, 0, '0);
      tag = "R10"; idle(3); steps(2); idle(2); steps(3);
      tag = "R6"; cyc(1, 0, 0, 0, 0, '0, 0, '0);
      anchor("R6", A_K1, 0);
      tag = "R7"; steps(4);
      cyc(1, 0, 1, 1, 1, KEY_B, 0, '0);          // start beats advance, old master used
      anchor("R7", A_K16, 0);
      steps(3);
      tag = "R8"; cyc(0, 0, 0, 0, 1, KEY_A, 1, KEY_A);
      cyc(0, 0, 0, 1, 1, KEY_B, 0, '0);
      idle(2); steps(12);
      tag = "R7"; cyc(1, 1, 1, 0, 0, '0, 1, KEY_B);  // uses working=KEY_A
      anchor("R7", A_K16, 0);
      tag = "R9"; cyc(0, 0, 0, 0, 1, KEY_A ^ 64'h0101010101010101, 0, '0);
      cyc(1, 0, 0, 0, 0, '0, 0, '0);
      anchor("R9", A_K1, 0);
      steps(15);
      anchor("R9", A_K16, 15);
      tag = "R3"; cyc(1, 1, 0, 0, 0, '0, 0, '0); steps(20);
      tag = "R4"; cyc(1, 1, 1, 0, 0, '0, 0, '0); steps(20);
      @(negedge clk); #1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule